// File: doc/BRIEF.md
# Cumulative Shift-Saturate Output Formatter

This block sits at the end of a histogram readout sweep. It receives a stream of wide accumulator words, one per valid cycle, and turns each word into a narrow result. The result can drive an output bus or be written back into a lookup table.

Three stages act in turn on each word. The first is an optional equalization stage. It replaces each word with the running total of every word seen since the sweep began, so a sweep over all bins yields a cumulative histogram. The second is a barrel shifter that picks a window of output-width bits from the wide value. The third is an optional clamp. When it is on and any set bit lies above the window, the result is forced to all ones. When it is off, the window is passed through truncated.

The sweep-start strobe resets the running total. The result appears one clock after its input word.

Top module: `cum_shift_fmt`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid is 0 and out_data is 0.
- R2: out_valid in cycle n+1 equals in_valid in cycle n.
- R3: With eq_en=0 and sat_en=0, a valid word yields out_data = in_data[shift+8:shift]. Window bits beyond bit 23 read as 0.
- R4: With sat_en=1, if any bit of the selected value above position shift+8 is 1, out_data is 511. Otherwise it is the window of R3.
- R5: With eq_en=1, the selected value is the running sum of all valid words since the last sweep_start, including the current word.
- R6: A sweep_start that coincides with a valid word begins the new sum with that word. A sweep_start with in_valid=0 clears the sum to zero.
- R7: The running sum is 24 bits wide and saturates at 16777215 instead of wrapping.
- R8: When in_valid is 0, out_data keeps its previous value and the running sum does not change.
- R9: At shift 15 the window is bits [23:15] padded with zeros, so saturation never triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_start | input | 1 | Restarts the running sum |
| in_valid | input | 1 | in_data carries a word this cycle |
| in_data | input | 24 | Accumulator word |
| eq_en | input | 1 | Select running sum instead of the word |
| sat_en | input | 1 | Clamp to all ones on lost upper bits |
| shift | input | 4 | Low bit index of the output window |
| out_valid | output | 1 | out_data updated this cycle |
| out_data | output | 9 | Formatted result |

## Verification
The assertions check on every cycle that the valid flag has one cycle of delay and that a detected overflow with the clamp enabled gives all ones. They also check that output and running sum hold through idle cycles, and that the running sum never decreases within a sweep. Whether the window lands on the right bits for each shift value, and whether the cumulative values are arithmetically correct, can only be shown by the bench's scenarios. The same is true of the restart behaviour of sweep_start and of saturation of the sum at its ceiling. The bench compares these against an independent reference model.

// File: rtl/cum_shift_fmt.sv
module cum_shift_fmt #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 9,
  parameter int SH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sweep_start,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic             eq_en,
  input  logic             sat_en,
  input  logic [SH_W-1:0]  shift,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam logic [IN_W-1:0]  SUM_MAX = '1;
  localparam logic [OUT_W-1:0] ALL_ONE = '1;

  logic [IN_W-1:0] acc_q;
  logic [IN_W-1:0] base;
  logic [IN_W:0]   raw_sum;
  logic [IN_W-1:0] sum_nxt;
  logic [IN_W-1:0] sel_val;
  logic [IN_W-1:0] win;
  logic            ovf;
  logic [OUT_W-1:0] fmt;

  assign base    = sweep_start ? '0 : acc_q;
  assign raw_sum = {1'b0, base} + {1'b0, in_data};
  assign sum_nxt = raw_sum[IN_W] ? SUM_MAX : raw_sum[IN_W-1:0];
  assign sel_val = eq_en ? sum_nxt : in_data;
  assign win     = sel_val >> shift;
  assign ovf     = |win[IN_W-1:OUT_W];
  assign fmt     = (sat_en && ovf) ? ALL_ONE : win[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_q    <= sum_nxt;
        out_data <= fmt;
      end else if (sweep_start) begin
        acc_q <= '0;
      end
    end
  end

  a_r2_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && ovf) |=> (out_data == ALL_ONE));
  a_r8_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !sweep_start) |=> ($stable(out_data) && $stable(acc_q)));
  a_r7_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sweep_start) |=> (acc_q >= $past(acc_q)));
  a_r9_top_window: assert property (@(posedge clk) disable iff (!rst_n)
    (shift == SH_W'(15) && IN_W == 24 && OUT_W == 9) |-> !ovf);
endmodule

// File: tb/sim_cum_shift_fmt.sv
module sim_cum_shift_fmt;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        sweep_start = 0;
  logic        in_valid = 0;
  logic [23:0] in_data = '0;
  logic        eq_en = 0;
  logic        sat_en = 0;
  logic [3:0]  shift = '0;
  logic        out_valid;
  logic [8:0]  out_data;

  int total = 0;
  int bad = 0;
  logic [23:0] m_sum = '0;
  logic [8:0]  m_out = '0;

  always #5 clk = ~clk;

  cum_shift_fmt u0 (.clk(clk), .rst_n(rst_n), .sweep_start(sweep_start),
    .in_valid(in_valid), .in_data(in_data), .eq_en(eq_en), .sat_en(sat_en),
    .shift(shift), .out_valid(out_valid), .out_data(out_data));

  function automatic logic [8:0] fmt_ref(input logic [23:0] v, input int sh, input bit sat);
    logic [23:0] w;
    w = v >> sh;
    if (sat && (w > 24'd511)) return 9'd511;
    return w[8:0];
  endfunction

  function automatic logic [23:0] add_ref(input logic [23:0] a, input logic [23:0] b);
    logic [24:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[24] ? 24'hFFFFFF : s[23:0];
  endfunction

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input logic [23:0] d, input bit ss,
                      input bit eq, input bit sat, input int sh);
    logic [23:0] base;
    @(negedge clk);
    in_valid = v; in_data = d; sweep_start = ss; eq_en = eq; sat_en = sat; shift = 4'(sh);
    base = ss ? 24'd0 : m_sum;
    if (v) begin
      m_sum = add_ref(base, d);
      m_out = fmt_ref(eq ? m_sum : d, sh, sat);
    end else if (ss) m_sum = '0;
    @(posedge clk); #1;
    check("R2", {8'd0, out_valid}, {8'd0, v});
    check(tag, out_data, m_out);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {8'd0, out_valid}, 9'd0);
    check("R1", out_data, 9'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1", {8'd0, out_valid}, 9'd0);
    check("R1", out_data, 9'd0);

    step("R3", 1, 24'h00ABCD, 1, 0, 0, 0);
    step("R3", 1, 24'h00ABCD, 0, 0, 0, 4);
    step("R3", 1, 24'hFFF000, 0, 0, 0, 2);
    step("R4", 1, 24'h000200, 0, 0, 1, 0);
    step("R4", 1, 24'h0001FF, 0, 0, 1, 0);
    step("R9", 1, 24'hFFFFFF, 0, 0, 1, 15);
    step("R9", 1, 24'h800000, 0, 0, 0, 15);
    step("R8", 0, 24'h123456, 0, 0, 0, 0);
    step("R8", 0, 24'h000000, 0, 1, 1, 3);

    step("R6", 0, 24'd0, 1, 1, 0, 0);
    step("R5", 1, 24'd10, 0, 1, 0, 0);
    step("R5", 1, 24'd20, 0, 1, 0, 0);
    step("R8", 0, 24'd99, 0, 1, 0, 0);
    step("R5", 1, 24'd5, 0, 1, 0, 0);
    step("R6", 1, 24'd7, 1, 1, 0, 0);
    step("R6", 1, 24'd1, 0, 1, 0, 0);

    step("R7", 1, 24'hF00000, 1, 1, 0, 15);
    step("R7", 1, 24'hF00000, 0, 1, 0, 15);
    step("R7", 1, 24'hFFFFFF, 0, 1, 0, 15);
    step("R7", 1, 24'h000000, 0, 1, 0, 0);
    step("R7", 1, 24'h000001, 0, 1, 0, 14);

    for (int i = 0; i < 600; i++) begin
      bit v, ss, eq, sat;
      int sh;
      logic [23:0] d;
      v   = ($urandom % 4) != 0;
      ss  = ($urandom % 16) == 0;
      eq  = $urandom % 2;
      sat = $urandom % 2;
      sh  = $urandom % 16;
      d   = ($urandom % 3 == 0) ? 24'($urandom) : 24'($urandom % 2048);
      step(!v ? "R8" : ss ? "R6" : eq ? "R5" : sat ? "R4" : "R3", v, d, ss, eq, sat, sh);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule